// File: doc/BRIEF.md
# Request-Driven Bit-Plane Snapshot Capture

This block takes one bit-plane of a fast sampled signal. The samples arrive as parallel words from an upstream 1:8 deserialiser, one word per capture-clock cycle. The block stays idle until a slower downstream processor asks for data. It then latches the next two consecutive input words into two alternating register banks. Together the banks form a 16-sample snapshot, one sample for each lag of a 16-lag correlator. The snapshot is offered to the processor on its own clock, and the block holds it unchanged until the processor acknowledges it.

Requests and completions cross between the two clocks as toggles, each passed through a two-flop synchroniser. The capture clock can therefore be faster or slower than the consumer clock and may change between acquisitions. Several instances placed side by side, one per sample bit, build a multibit sample. Both resets must be asserted together, because each side keeps a copy of the toggle levels.

Top module: `bitplane_snap`

## Requirements
- R1: While both resets are high and right after they are released, `pkt_valid` is 0 and `pkt_data` is all zeros.
- R2: Without an acquisition request, `pkt_valid` stays 0 no matter how the input words change.
- R3: After an accepted request, `pkt_valid` rises. `pkt_data[7:0]` holds the earlier of two consecutive input words, with bit 0 of that word (the earliest sample) in `pkt_data[0]`.
- R4: `pkt_data[15:8]` holds the input word that arrived on the capture cycle directly after the word in `pkt_data[7:0]`.
- R5: While `pkt_valid` is 1 and no acknowledge has been given, `pkt_data` does not change, even though the input keeps moving.
- R6: `pkt_valid` stays 1 until `pkt_ack` is sampled high, and it is 0 on the next consumer-clock cycle.
- R7: A request made while a capture is in flight or a packet is held is dropped. No further packet appears after that packet is acknowledged.
- R8: R3 and R4 hold for capture clocks faster than, slower than and changing relative to the consumer clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cap_clk | input | 1 | Capture clock, one input word per cycle |
| cap_rst | input | 1 | Synchronous active-high reset, capture side |
| cap_word | input | 8 | Deserialised samples, bit 0 earliest |
| con_clk | input | 1 | Consumer clock |
| con_rst | input | 1 | Synchronous active-high reset, consumer side |
| acq_req | input | 1 | One-cycle acquisition request |
| pkt_ack | input | 1 | Consumer takes the held packet |
| pkt_valid | output | 1 | A snapshot is held and readable |
| pkt_data | output | 16 | Snapshot, bit n is sample n |

## Verification
The input is driven as a running word counter with strides from 1 to 6. A correct snapshot then shows upper minus lower equal to the stride. That test catches a swapped bank order, a skipped word and a bank latched twice. The sweep repeats under capture clocks faster, equal to and slower than the consumer clock, which shows that the handshake does not rely on a clock ratio. An extra request is issued while each packet is held. The bench then watches the output for frozen data and for the absence of a spurious second packet after the acknowledge.

// File: rtl/bitplane_snap_pkg.sv
`timescale 1ns/1ps
package bitplane_snap_pkg;
    typedef enum logic {
        CAP_IDLE,
        CAP_GRAB
    } cap_state_e;

    typedef enum logic [1:0] {
        CON_IDLE,
        CON_WAIT,
        CON_HOLD
    } con_state_e;

    // a toggle has moved since it was last seen
    function automatic logic tgl_moved(input logic now_v, input logic last_v);
        return now_v ^ last_v;
    endfunction
endpackage

// File: rtl/bitplane_snap_sync.sv
`timescale 1ns/1ps
module bitplane_snap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/bitplane_snap_capture.sv
`timescale 1ns/1ps
module bitplane_snap_capture
    import bitplane_snap_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int NBANK  = 2,
    localparam int PKT_W = WORD_W * NBANK,
    localparam int IDX_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_in,
    input  logic              req_tgl_s,
    output logic              done_tgl,
    output logic [PKT_W-1:0]  pkt
);
    cap_state_e       state_q;
    logic [IDX_W-1:0] idx_q;
    logic             req_last_q;
    logic             start;
    logic             last_bank;

    assign start     = (state_q == CAP_IDLE) && tgl_moved(req_tgl_s, req_last_q);
    assign last_bank = (idx_q == IDX_W'(NBANK - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= CAP_IDLE;
            idx_q      <= '0;
            req_last_q <= 1'b0;
            done_tgl   <= 1'b0;
        end else begin
            req_last_q <= req_tgl_s;
            case (state_q)
                CAP_IDLE: begin
                    idx_q <= '0;
                    if (start) state_q <= CAP_GRAB;
                end
                CAP_GRAB: begin
                    if (last_bank) begin
                        state_q  <= CAP_IDLE;
                        idx_q    <= '0;
                        done_tgl <= ~done_tgl;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: state_q <= CAP_IDLE;
            endcase
        end
    end

    // one bank per input word; bank 0 takes the earliest word
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic [WORD_W-1:0] bank_q;
        always_ff @(posedge clk) begin
            if (rst)
                bank_q <= '0;
            else if (state_q == CAP_GRAB && idx_q == IDX_W'(g))
                bank_q <= word_in;
        end
        assign pkt[g*WORD_W +: WORD_W] = bank_q;
    end
endmodule

// File: rtl/bitplane_snap_consumer.sv
`timescale 1ns/1ps
module bitplane_snap_consumer
    import bitplane_snap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic acq_req,
    input  logic pkt_ack,
    input  logic done_tgl_s,
    output logic req_tgl,
    output logic pkt_valid
);
    con_state_e state_q;
    logic       done_last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= CON_IDLE;
            done_last_q <= 1'b0;
            req_tgl     <= 1'b0;
        end else begin
            done_last_q <= done_tgl_s;
            case (state_q)
                CON_IDLE: if (acq_req) begin
                    req_tgl <= ~req_tgl;
                    state_q <= CON_WAIT;
                end
                CON_WAIT: if (tgl_moved(done_tgl_s, done_last_q)) state_q <= CON_HOLD;
                CON_HOLD: if (pkt_ack) state_q <= CON_IDLE;
                default:  state_q <= CON_IDLE;
            endcase
        end
    end

    assign pkt_valid = (state_q == CON_HOLD);
endmodule

// File: rtl/bitplane_snap.sv
`timescale 1ns/1ps
module bitplane_snap #(
    parameter int WORD_W      = 8,
    parameter int NBANK       = 2,
    parameter int SYNC_STAGES = 2,
    localparam int PKT_W      = WORD_W * NBANK
) (
    input  logic              cap_clk,
    input  logic              cap_rst,
    input  logic [WORD_W-1:0] cap_word,
    input  logic              con_clk,
    input  logic              con_rst,
    input  logic              acq_req,
    input  logic              pkt_ack,
    output logic              pkt_valid,
    output logic [PKT_W-1:0]  pkt_data
);
    logic req_tgl, req_tgl_s;
    logic done_tgl, done_tgl_s;

    bitplane_snap_consumer u_con (
        .clk        (con_clk),
        .rst        (con_rst),
        .acq_req    (acq_req),
        .pkt_ack    (pkt_ack),
        .done_tgl_s (done_tgl_s),
        .req_tgl    (req_tgl),
        .pkt_valid  (pkt_valid)
    );

    bitplane_snap_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk (cap_clk),
        .rst (cap_rst),
        .d   (req_tgl),
        .q   (req_tgl_s)
    );

    bitplane_snap_capture #(.WORD_W(WORD_W), .NBANK(NBANK)) u_cap (
        .clk       (cap_clk),
        .rst       (cap_rst),
        .word_in   (cap_word),
        .req_tgl_s (req_tgl_s),
        .done_tgl  (done_tgl),
        .pkt       (pkt_data)
    );

    bitplane_snap_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
        .clk (con_clk),
        .rst (con_rst),
        .d   (done_tgl),
        .q   (done_tgl_s)
    );
endmodule

// File: rtl/bitplane_snap_chk.sv
`timescale 1ns/1ps
module bitplane_snap_chk #(
    parameter int PKT_W = 16
) (
    input logic             con_clk,
    input logic             con_rst,
    input logic             pkt_ack,
    input logic             pkt_valid,
    input logic [PKT_W-1:0] pkt_data
);
    // R1
    reset_clear_chk: assert property (@(posedge con_clk) disable iff (con_rst)
        $fell(con_rst) |-> (!pkt_valid && pkt_data == '0));

    // R5
    held_data_chk: assert property (@(posedge con_clk) disable iff (con_rst)
        (pkt_valid && !pkt_ack) |=> $stable(pkt_data));

    // R6
    valid_hold_chk: assert property (@(posedge con_clk) disable iff (con_rst)
        (pkt_valid && !pkt_ack) |=> pkt_valid);

    // R6
    ack_drop_chk: assert property (@(posedge con_clk) disable iff (con_rst)
        (pkt_valid && pkt_ack) |=> !pkt_valid);
endmodule

bind bitplane_snap bitplane_snap_chk #(.PKT_W(PKT_W)) u_chk (
    .con_clk   (con_clk),
    .con_rst   (con_rst),
    .pkt_ack   (pkt_ack),
    .pkt_valid (pkt_valid),
    .pkt_data  (pkt_data)
);

// File: tb/test_bitplane_snap.sv
`timescale 1ns/1ps
module test_bitplane_snap;
    logic        cap_clk = 1'b0;
    logic        con_clk = 1'b0;
    logic        cap_rst = 1'b1;
    logic        con_rst = 1'b1;
    logic [7:0]  cap_word = 8'd0;
    logic        acq_req = 1'b0;
    logic        pkt_ack = 1'b0;
    logic        pkt_valid;
    logic [15:0] pkt_data;

    realtime cap_half = 3.0;
    logic [7:0] stride = 8'd1;
    int total = 0;
    int bad = 0;
    bit ended = 0;

    bitplane_snap i_bitplane_snap (
        .cap_clk   (cap_clk),
        .cap_rst   (cap_rst),
        .cap_word  (cap_word),
        .con_clk   (con_clk),
        .con_rst   (con_rst),
        .acq_req   (acq_req),
        .pkt_ack   (pkt_ack),
        .pkt_valid (pkt_valid),
        .pkt_data  (pkt_data)
    );

    always #4 con_clk = ~con_clk;
    always #(cap_half) cap_clk = ~cap_clk;

    initial begin
        forever begin
            @(posedge cap_clk);
            cap_word <= cap_word + stride;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up;
        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic con_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge con_clk);
    endtask

    task automatic acquire(input string tag);
        logic [15:0] snap;
        bit          seen;
        logic [7:0]  diff;
        @(negedge con_clk); acq_req = 1'b1;
        @(negedge con_clk); acq_req = 1'b0;
        seen = 0;
        for (int i = 0; i < 300 && !seen; i++) begin
            @(negedge con_clk);
            seen = pkt_valid;
        end
        check(seen, {"R3 valid after request ", tag}, int'(pkt_valid), 1);
        snap = pkt_data;
        diff = snap[15:8] - snap[7:0];
        // R3 R4 R8: low byte earlier, high byte the next word
        check(diff == stride, {"R4 consecutive words ", tag}, int'(diff), int'(stride));
        // R7: extra request while held
        @(negedge con_clk); acq_req = 1'b1;
        @(negedge con_clk); acq_req = 1'b0;
        con_cycles(10);
        check(pkt_valid == 1'b1, {"R6 valid held ", tag}, int'(pkt_valid), 1);
        check(pkt_data == snap, {"R5 data frozen ", tag}, int'(pkt_data), int'(snap));
        pkt_ack = 1'b1;
        @(negedge con_clk); pkt_ack = 1'b0;
        check(pkt_valid == 1'b0, {"R6 drop after ack ", tag}, int'(pkt_valid), 0);
        seen = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge con_clk);
            if (pkt_valid) seen = 1;
        end
        check(!seen, {"R7 dropped request ", tag}, int'(seen), 0);
    endtask

    initial begin
        bit spurious;
        con_cycles(3);
        // R1 during reset
        check(pkt_valid == 1'b0, "R1 valid in reset", int'(pkt_valid), 0);
        @(negedge con_clk);
        cap_rst = 1'b0;
        con_rst = 1'b0;
        @(negedge con_clk);
        check(pkt_valid == 1'b0, "R1 valid after reset", int'(pkt_valid), 0);
        check(pkt_data == 16'h0, "R1 data after reset", int'(pkt_data), 0);
        // R2: no request, input running
        spurious = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge con_clk);
            if (pkt_valid) spurious = 1;
        end
        check(!spurious, "R2 no packet without request", int'(spurious), 0);
        // R8 sweep over capture clock ratios and strides
        for (int p = 0; p < 3; p++) begin
            cap_half = (p == 0) ? 3.0 : (p == 1) ? 4.0 : 7.0;
            for (int s = 1; s <= 6; s++) begin
                stride = 8'(s);
                acquire($sformatf("R8 half=%0.1f stride=%0d", cap_half, s));
            end
        end
        // R1 again: reset mid-stream
        @(negedge con_clk); cap_rst = 1'b1; con_rst = 1'b1;
        con_cycles(3);
        cap_rst = 1'b0; con_rst = 1'b0;
        @(negedge con_clk);
        check(pkt_data == 16'h0, "R1 data after second reset", int'(pkt_data), 0);
        acquire("after second reset");
        finish_up();
    end

    initial begin
        #1500000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        finish_up();
    end
endmodule